// File: doc/BRIEF.md
# Boot Sector Partition Table Scanner

This block watches a 512-byte boot sector go past as a byte stream and pulls the partition table out of it without storing the sector. Each byte comes with a valid strobe, an end-of-sector marker and the byte's position in the sector. The parser skips the loader area at the front and decodes the four 16-byte table slots as they stream by. It checks the two signature bytes at the tail. At the end of the sector it reports the one bootable partition: its slot number, type code, first sector and sector count.

One cycle after the final byte, a single-cycle completion strobe rises. On the same edge the verdict flags and the result fields update, and they hold until the next completion. A sector is accepted only when the signature is correct, every status byte is legal and exactly one used slot is bootable. Otherwise the result fields read zero and the flags say what went wrong. When the stream is framed wrongly, a length error is reported. The parser then drops input up to the next end marker, so the next sector starts clean.

Top module: `mbr_scanner`

## Requirements
- R1: After reset, done_o, ok_o, every error flag, part_idx_o, start_lba_o, sect_cnt_o and part_type_o are all zero.
- R2: Bytes at positions 0 to 445 do not change any output.
- R3: Slot n (0 to 3) starts at byte 446+16n. Its bytes are: status at +0, type at +4, first sector at +8..+11, sector count at +12..+15, both fields little-endian. For an accepted sector the outputs give the bootable slot's number, type, first sector and count.
- R4: A slot with type byte 0x00 is never selected and is not counted as bootable, even when its status is 0x80.
- R5: The signature is correct only when byte 510 is 0x55 and byte 511 is 0xAA. Any other value sets err_sig_o and rejects the sector. A rejected sector has ok_o low and part_idx_o, start_lba_o, sect_cnt_o and part_type_o zero.
- R6: A status byte of 0x80 means bootable and 0x00 means not bootable. Any other status value in any slot sets err_status_o and rejects the sector.
- R7: Two or more bootable used slots set err_multi_o and reject the sector.
- R8: No bootable used slot sets err_none_o and rejects the sector.
- R9: An end marker before byte 511, or a byte 511 without an end marker, ends the sector at once. It raises done_o with err_len_o set and every other flag clear. The parser then ignores input up to and including the next end marker, and the following sector is parsed normally.
- R10: A byte whose index sideband differs from its actual position in the stream is treated as a length error, with the same effects as R9.
- R11: done_o is high for exactly one cycle per sector, in the cycle after the edge that takes the final or failing byte. The outputs hold their values between completions.
- R12: Cycles with valid_i low are ignored, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte strobe |
| last_i | input | 1 | Marks the final byte of a sector |
| idx_i | input | 9 | Position of the byte in the sector |
| data_i | input | 8 | Sector byte |
| done_o | output | 1 | One-cycle completion strobe |
| ok_o | output | 1 | Sector accepted, result fields valid |
| part_idx_o | output | 2 | Selected slot number |
| start_lba_o | output | 32 | First sector of the selected partition |
| sect_cnt_o | output | 32 | Sector count of the selected partition |
| part_type_o | output | 8 | Type code of the selected partition |
| err_sig_o | output | 1 | Signature wrong |
| err_status_o | output | 1 | Illegal status byte seen |
| err_multi_o | output | 1 | More than one bootable slot |
| err_none_o | output | 1 | No bootable slot |
| err_len_o | output | 1 | Framing or index error |

## Verification
The bench uses the default parameters: a 512-byte sector, the table at byte 446, and four 16-byte slots. With these it can hit every slot as the winner, both signature positions, the 512-byte length boundary in both directions, and index slips in the middle of the loader area. Random sectors mix legal, illegal and unused slots with random idle gaps, and a bench model computes the expected result for each one. Directed sectors force the single-slot, duplicate, empty and framing cases.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  localparam logic [7:0] STAT_BOOT = 8'h80;
  localparam logic [7:0] STAT_IDLE = 8'h00;
  localparam logic [7:0] SIG_LO    = 8'h55;
  localparam logic [7:0] SIG_HI    = 8'hAA;
  localparam int FLD_STATUS = 0;
  localparam int FLD_TYPE   = 4;
  localparam int FLD_LBA    = 8;
  localparam int FLD_CNT    = 12;

  typedef struct packed {
    logic [31:0] lba;
    logic [31:0] cnt;
    logic [7:0]  ptype;
  } part_info_t;

  typedef struct packed {
    logic ok;
    logic sig;
    logic status;
    logic multi;
    logic none;
    logic len;
  } verdict_t;
endpackage

// File: rtl/mbr_stream_tracker.sv
module mbr_stream_tracker #(
  parameter int SECTOR_BYTES = 512,
  parameter int TABLE_OFFSET = 446,
  parameter int ENTRY_BYTES  = 16,
  parameter int NUM_ENTRIES  = 4,
  parameter int IDX_W        = 9,
  parameter int ENTRY_W      = 4,
  parameter int ENT_W        = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               last_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic               take_o,
  output logic               end_ok_o,
  output logic               err_o,
  output logic               tbl_o,
  output logic               sig_lo_o,
  output logic [ENT_W-1:0]   ent_o,
  output logic [ENTRY_W-1:0] fld_o
);
  localparam int TABLE_END = TABLE_OFFSET + NUM_ENTRIES * ENTRY_BYTES;
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(SECTOR_BYTES - 1);
  localparam logic [IDX_W-1:0] SIG_POS  = IDX_W'(SECTOR_BYTES - 2);
  localparam logic [IDX_W-1:0] TBL_LO   = IDX_W'(TABLE_OFFSET);
  localparam logic [IDX_W-1:0] TBL_HI   = IDX_W'(TABLE_END);

  logic [IDX_W-1:0] pos_q;
  logic             flush_q;
  logic             at_end, live, bad;
  logic [IDX_W-1:0] rel;

  assign at_end = (pos_q == LAST_POS);
  assign live   = valid_i && !flush_q;
  assign bad    = live && ((idx_i != pos_q) || (last_i != at_end));

  assign take_o   = live && !bad;
  assign end_ok_o = take_o && at_end;
  assign err_o    = bad;
  assign sig_lo_o = take_o && (pos_q == SIG_POS);
  assign tbl_o    = (pos_q >= TBL_LO) && (pos_q < TBL_HI);
  assign rel      = pos_q - TBL_LO;
  assign ent_o    = ENT_W'(rel >> ENTRY_W);
  assign fld_o    = ENTRY_W'(rel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      flush_q <= 1'b0;
    end else if (valid_i) begin
      if (flush_q) begin
        if (last_i) flush_q <= 1'b0;
      end else if (bad) begin
        pos_q   <= '0;
        flush_q <= !last_i;
      end else if (at_end) begin
        pos_q <= '0;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mbr_entry_capture.sv
module mbr_entry_capture
  import mbr_pkg::*;
#(
  parameter int ENTRY_BYTES = 16,
  parameter int ENTRY_W     = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_i,
  input  logic               tbl_i,
  input  logic [ENTRY_W-1:0] fld_i,
  input  logic [7:0]         data_i,
  output logic               entry_done_o,
  output logic               boot_o,
  output logic               status_err_o,
  output part_info_t         info_o
);
  logic [7:0]  status_q, ptype_q;
  logic [31:0] lba_q;
  logic [23:0] cnt_q;
  logic        sel;
  int          f;

  assign sel = take_i && tbl_i;
  assign f   = int'(fld_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      ptype_q  <= '0;
      lba_q    <= '0;
      cnt_q    <= '0;
    end else if (sel) begin
      if (f == FLD_STATUS) status_q <= data_i;
      if (f == FLD_TYPE)   ptype_q  <= data_i;
      if (f >= FLD_LBA && f < FLD_LBA + 4) lba_q <= {data_i, lba_q[31:8]};
      if (f >= FLD_CNT && f < FLD_CNT + 3) cnt_q <= {data_i, cnt_q[23:8]};
    end
  end

  // final count byte is still on the bus when the entry completes
  assign entry_done_o = sel && (f == ENTRY_BYTES - 1);
  assign boot_o       = (status_q == STAT_BOOT) && (ptype_q != 8'h00);
  assign status_err_o = sel && (f == FLD_STATUS) &&
                        (data_i != STAT_BOOT) && (data_i != STAT_IDLE);
  assign info_o.lba   = lba_q;
  assign info_o.cnt   = {data_i, cnt_q};
  assign info_o.ptype = ptype_q;
endmodule

// File: rtl/mbr_verdict.sv
module mbr_verdict
  import mbr_pkg::*;
#(
  parameter int ENT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             end_ok_i,
  input  logic             err_i,
  input  logic             sig_lo_i,
  input  logic             entry_done_i,
  input  logic             boot_i,
  input  logic             status_err_i,
  input  logic [ENT_W-1:0] ent_i,
  input  part_info_t       info_i,
  input  logic [7:0]       data_i,
  output logic             done_o,
  output verdict_t         verdict_o,
  output part_info_t       result_o,
  output logic [ENT_W-1:0] part_idx_o
);
  logic [1:0]       act_q;
  logic             stat_q, lo_ok_q;
  part_info_t       sel_q;
  logic [ENT_W-1:0] sel_idx_q;
  logic             sig_ok, accept;

  assign sig_ok = lo_ok_q && (data_i == SIG_HI);
  assign accept = sig_ok && (act_q == 2'd1) && !stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= '0;
      stat_q    <= 1'b0;
      lo_ok_q   <= 1'b0;
      sel_q     <= '0;
      sel_idx_q <= '0;
    end else if (err_i || end_ok_i) begin
      act_q     <= '0;
      stat_q    <= 1'b0;
      lo_ok_q   <= 1'b0;
      sel_q     <= '0;
      sel_idx_q <= '0;
    end else begin
      if (entry_done_i && boot_i) begin
        act_q <= (act_q == 2'd2) ? 2'd2 : act_q + 2'd1;
        if (act_q == 2'd0) begin
          sel_q     <= info_i;
          sel_idx_q <= ent_i;
        end
      end
      if (status_err_i) stat_q <= 1'b1;
      if (sig_lo_i) lo_ok_q <= (data_i == SIG_LO);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      verdict_o  <= '0;
      result_o   <= '0;
      part_idx_o <= '0;
    end else begin
      done_o <= err_i || end_ok_i;
      if (err_i) begin
        verdict_o     <= '0;
        verdict_o.len <= 1'b1;
        result_o      <= '0;
        part_idx_o    <= '0;
      end else if (end_ok_i) begin
        verdict_o.ok     <= accept;
        verdict_o.sig    <= !sig_ok;
        verdict_o.status <= stat_q;
        verdict_o.multi  <= (act_q == 2'd2);
        verdict_o.none   <= (act_q == 2'd0);
        verdict_o.len    <= 1'b0;
        result_o         <= accept ? sel_q : '0;
        part_idx_o       <= accept ? sel_idx_q : '0;
      end
    end
  end
endmodule

// File: rtl/mbr_scanner.sv
module mbr_scanner
  import mbr_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int TABLE_OFFSET = 446,
  parameter int ENTRY_BYTES  = 16,
  parameter int NUM_ENTRIES  = 4,
  localparam int IDX_W   = $clog2(SECTOR_BYTES),
  localparam int ENTRY_W = $clog2(ENTRY_BYTES),
  localparam int ENT_W   = $clog2(NUM_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             last_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  output logic             done_o,
  output logic             ok_o,
  output logic [ENT_W-1:0] part_idx_o,
  output logic [31:0]      start_lba_o,
  output logic [31:0]      sect_cnt_o,
  output logic [7:0]       part_type_o,
  output logic             err_sig_o,
  output logic             err_status_o,
  output logic             err_multi_o,
  output logic             err_none_o,
  output logic             err_len_o
);
  logic               take, end_ok, err, tbl, sig_lo;
  logic [ENT_W-1:0]   ent;
  logic [ENTRY_W-1:0] fld;
  logic               entry_done, boot, status_err;
  part_info_t         info, result;
  verdict_t           verdict;

  mbr_stream_tracker #(
    .SECTOR_BYTES(SECTOR_BYTES), .TABLE_OFFSET(TABLE_OFFSET),
    .ENTRY_BYTES(ENTRY_BYTES), .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W(IDX_W), .ENTRY_W(ENTRY_W), .ENT_W(ENT_W)
  ) u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .last_i(last_i),
    .idx_i(idx_i), .take_o(take), .end_ok_o(end_ok), .err_o(err),
    .tbl_o(tbl), .sig_lo_o(sig_lo), .ent_o(ent), .fld_o(fld)
  );

  mbr_entry_capture #(
    .ENTRY_BYTES(ENTRY_BYTES), .ENTRY_W(ENTRY_W)
  ) u_entry (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take), .tbl_i(tbl),
    .fld_i(fld), .data_i(data_i), .entry_done_o(entry_done),
    .boot_o(boot), .status_err_o(status_err), .info_o(info)
  );

  mbr_verdict #(.ENT_W(ENT_W)) u_verdict (
    .clk_i(clk_i), .rst_ni(rst_ni), .end_ok_i(end_ok), .err_i(err),
    .sig_lo_i(sig_lo), .entry_done_i(entry_done), .boot_i(boot),
    .status_err_i(status_err), .ent_i(ent), .info_i(info),
    .data_i(data_i), .done_o(done_o), .verdict_o(verdict),
    .result_o(result), .part_idx_o(part_idx_o)
  );

  assign ok_o         = verdict.ok;
  assign err_sig_o    = verdict.sig;
  assign err_status_o = verdict.status;
  assign err_multi_o  = verdict.multi;
  assign err_none_o   = verdict.none;
  assign err_len_o    = verdict.len;
  assign start_lba_o  = result.lba;
  assign sect_cnt_o   = result.cnt;
  assign part_type_o  = result.ptype;
endmodule

// File: rtl/mbr_scanner_chk.sv
module mbr_scanner_chk #(
  parameter int ENT_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_o,
  input logic             ok_o,
  input logic [ENT_W-1:0] part_idx_o,
  input logic [31:0]      start_lba_o,
  input logic [31:0]      sect_cnt_o,
  input logic [7:0]       part_type_o,
  input logic             err_sig_o,
  input logic             err_status_o,
  input logic             err_multi_o,
  input logic             err_none_o,
  input logic             err_len_o
);
  AST_REJECT_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ok_o |-> (start_lba_o == '0 && sect_cnt_o == '0 && part_type_o == '0 && part_idx_o == '0)); // R5

  AST_ACCEPT_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> !(err_sig_o || err_status_o || err_multi_o || err_none_o || err_len_o)); // R6

  AST_LEN_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_len_o |-> !(err_sig_o || err_status_o || err_multi_o || err_none_o)); // R9

  AST_ACTIVE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_multi_o && err_none_o)); // R7

  AST_TYPE_USED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> part_type_o != 8'h00); // R4

  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({ok_o, part_idx_o, start_lba_o, sect_cnt_o, part_type_o,
                         err_sig_o, err_status_o, err_multi_o, err_none_o, err_len_o})); // R11
endmodule

bind mbr_scanner mbr_scanner_chk #(.ENT_W(ENT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o), .ok_o(ok_o),
  .part_idx_o(part_idx_o), .start_lba_o(start_lba_o), .sect_cnt_o(sect_cnt_o),
  .part_type_o(part_type_o), .err_sig_o(err_sig_o), .err_status_o(err_status_o),
  .err_multi_o(err_multi_o), .err_none_o(err_none_o), .err_len_o(err_len_o)
);

// File: tb/tb_mbr_scanner.sv
`timescale 1ns/1ps
module tb_mbr_scanner;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid, last;
  logic [8:0]  idx;
  logic [7:0]  data;
  logic        done_o, ok_o, err_sig_o, err_status_o, err_multi_o, err_none_o, err_len_o;
  logic [1:0]  part_idx_o;
  logic [31:0] start_lba_o, sect_cnt_o;
  logic [7:0]  part_type_o;

  always #2 clk = ~clk;

  mbr_scanner dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .last_i(last), .idx_i(idx),
    .data_i(data), .done_o(done_o), .ok_o(ok_o), .part_idx_o(part_idx_o),
    .start_lba_o(start_lba_o), .sect_cnt_o(sect_cnt_o), .part_type_o(part_type_o),
    .err_sig_o(err_sig_o), .err_status_o(err_status_o), .err_multi_o(err_multi_o),
    .err_none_o(err_none_o), .err_len_o(err_len_o)
  );

  int n_chk = 0, n_err = 0, done_cnt = 0;
  bit finished = 0;
  logic [7:0] sec [512];

  logic        s_valid, s_ok, s_sig, s_stat, s_multi, s_none, s_len;
  logic [1:0]  s_idx;
  logic [31:0] s_lba, s_cnt;
  logic [7:0]  s_type;

  logic        e_ok, e_sig, e_stat, e_multi, e_none, e_len;
  logic [1:0]  e_idx;
  logic [31:0] e_lba, e_cnt;
  logic [7:0]  e_type;

  always @(posedge clk) begin
    #1;
    if (done_o) begin
      done_cnt++;
      s_valid = valid; s_ok = ok_o; s_sig = err_sig_o; s_stat = err_status_o;
      s_multi = err_multi_o; s_none = err_none_o; s_len = err_len_o;
      s_idx = part_idx_o; s_lba = start_lba_o; s_cnt = sect_cnt_o; s_type = part_type_o;
    end
  end

  task automatic chk(input bit cond, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!cond) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic put_entry(input int e, input logic [7:0] st, input logic [7:0] ty,
                           input logic [31:0] lba, input logic [31:0] cnt);
    int b = 446 + 16 * e;
    sec[b] = st;
    sec[b + 4] = ty;
    for (int k = 0; k < 4; k++) begin
      sec[b + 8 + k]  = lba[8*k +: 8];
      sec[b + 12 + k] = cnt[8*k +: 8];
    end
  endtask

  task automatic fresh_sector();
    for (int i = 0; i < 512; i++) sec[i] = 8'($urandom);
    for (int e = 0; e < 4; e++) put_entry(e, 8'h00, 8'h00, $urandom, $urandom);
    sec[510] = 8'h55;
    sec[511] = 8'hAA;
  endtask

  task automatic model();
    int act = 0;
    int b;
    e_stat = 0; e_len = 0; e_idx = 0; e_lba = 0; e_cnt = 0; e_type = 0;
    e_sig = !(sec[510] == 8'h55 && sec[511] == 8'hAA);
    for (int e = 0; e < 4; e++) begin
      b = 446 + 16 * e;
      if (sec[b] != 8'h00 && sec[b] != 8'h80) e_stat = 1;
      if (sec[b] == 8'h80 && sec[b + 4] != 8'h00) begin
        act++;
        if (act == 1) begin
          e_idx = 2'(e); e_type = sec[b + 4];
          e_lba = {sec[b+11], sec[b+10], sec[b+9], sec[b+8]};
          e_cnt = {sec[b+15], sec[b+14], sec[b+13], sec[b+12]};
        end
      end
    end
    e_multi = (act >= 2);
    e_none  = (act == 0);
    e_ok    = !e_sig && !e_stat && act == 1;
    if (!e_ok) begin e_idx = 0; e_lba = 0; e_cnt = 0; e_type = 0; end
  endtask

  task automatic model_len();
    e_ok = 0; e_sig = 0; e_stat = 0; e_multi = 0; e_none = 0; e_len = 1;
    e_idx = 0; e_lba = 0; e_cnt = 0; e_type = 0;
  endtask

  task automatic send(input int n, input int last_at, input int bad_at, input int gap);
    done_cnt = 0;
    for (int i = 0; i < n; i++) begin
      while (int'($urandom % 100) < gap) begin
        @(negedge clk);
        valid = 0; data = 8'($urandom); last = 1'($urandom); idx = 9'($urandom);
      end
      @(negedge clk);
      valid = 1; data = sec[i % 512]; idx = 9'(i); last = (i == last_at);
      if (i == bad_at) idx = idx ^ 9'h5;
    end
    @(negedge clk);
    valid = 0; last = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(input string req);
    chk(done_cnt == 1, "R11", "done pulses", done_cnt, 1);
    chk(s_valid == 1, "R11", "done timing", s_valid, 1);
    chk(s_ok == e_ok, req, "ok", s_ok, e_ok);
    chk(s_sig == e_sig, "R5", "err_sig", s_sig, e_sig);
    chk(s_stat == e_stat, "R6", "err_status", s_stat, e_stat);
    chk(s_multi == e_multi, "R7", "err_multi", s_multi, e_multi);
    chk(s_none == e_none, "R8", "err_none", s_none, e_none);
    chk(s_len == e_len, "R9", "err_len", s_len, e_len);
    chk(s_idx == e_idx, "R3", "part_idx", s_idx, e_idx);
    chk(s_lba == e_lba, "R3", "start_lba", s_lba, e_lba);
    chk(s_cnt == e_cnt, "R3", "sect_cnt", s_cnt, e_cnt);
    chk(s_type == e_type, "R3", "part_type", s_type, e_type);
  endtask

  task automatic run_good(input string req, input int gap);
    model();
    send(512, 511, -1, gap);
    compare(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL R11 watchdog expired act=0 exp=1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1bad));
    rst_n = 0; valid = 0; last = 0; idx = 0; data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({done_o, ok_o, err_sig_o, err_status_o, err_multi_o, err_none_o, err_len_o} == 0,
        "R1", "flags after reset", {done_o, ok_o, err_sig_o}, 0);
    chk({part_idx_o, start_lba_o, sect_cnt_o, part_type_o} == 0,
        "R1", "fields after reset", start_lba_o, 0);

    // R3: each slot as the sole winner
    for (int e = 0; e < 4; e++) begin
      fresh_sector();
      put_entry(e, 8'h80, 8'h83, 32'h1234_5678 + e, 32'hA0B1_C2D3);
      run_good("R3", 10);
    end

    // R2: boot code contents changed, table kept
    fresh_sector();
    put_entry(2, 8'h80, 8'h0C, 32'h0000_0800, 32'h0010_0000);
    run_good("R2", 0);
    for (int i = 0; i < 446; i++) sec[i] = ~sec[i];
    run_good("R2", 0);

    // R4: unused slot flagged bootable is skipped
    fresh_sector();
    put_entry(1, 8'h80, 8'h00, 32'h1111, 32'h2222);
    put_entry(3, 8'h80, 8'h07, 32'h3333, 32'h4444);
    run_good("R4", 5);
    put_entry(3, 8'h00, 8'h07, 32'h3333, 32'h4444);
    run_good("R4", 5);

    // R5: swapped signature bytes
    fresh_sector();
    put_entry(0, 8'h80, 8'h83, 32'h800, 32'h900);
    sec[510] = 8'hAA; sec[511] = 8'h55;
    run_good("R5", 5);

    // R6: illegal status
    fresh_sector();
    put_entry(0, 8'h80, 8'h83, 32'h800, 32'h900);
    put_entry(2, 8'h81, 8'h05, 32'h1, 32'h2);
    run_good("R6", 5);

    // R7: two bootable slots
    fresh_sector();
    put_entry(0, 8'h80, 8'h83, 32'h800, 32'h900);
    put_entry(3, 8'h80, 8'h82, 32'h1800, 32'h1900);
    run_good("R7", 5);

    // R8: nothing bootable
    fresh_sector();
    put_entry(1, 8'h00, 8'h83, 32'h800, 32'h900);
    run_good("R8", 5);

    // R9: premature end, then a clean sector
    fresh_sector();
    put_entry(1, 8'h80, 8'h83, 32'h800, 32'h900);
    model_len();
    send(301, 300, -1, 5);
    compare("R9");
    run_good("R9", 5);

    // R9: overlong stream, flushed to its end marker
    model_len();
    send(513, 512, -1, 5);
    compare("R9");
    run_good("R9", 5);

    // R10: index slip inside boot code, rest of stream dropped
    model_len();
    send(512, 511, 100, 5);
    compare("R10");
    run_good("R10", 5);

    // R11/R12: heavy idle gaps with noise, then results held
    fresh_sector();
    put_entry(2, 8'h80, 8'hEE, 32'hDEAD_BEEF, 32'h0BAD_F00D);
    run_good("R12", 60);
    repeat (20) @(negedge clk);
    chk(done_o == 0, "R11", "done low when idle", done_o, 0);
    chk(ok_o == s_ok && start_lba_o == s_lba && sect_cnt_o == s_cnt,
        "R11", "result held", start_lba_o, s_lba);

    // random sectors
    for (int t = 0; t < 40; t++) begin
      int r;
      fresh_sector();
      for (int e = 0; e < 4; e++) begin
        logic [7:0] st, ty;
        r = int'($urandom % 10);
        st = (r < 3) ? 8'h80 : (r < 9) ? 8'h00 : 8'(1 + $urandom % 127);
        ty = ($urandom % 4 == 0) ? 8'h00 : (8'($urandom) | 8'h01);
        put_entry(e, st, ty, $urandom, $urandom);
      end
      if ($urandom % 10 == 0) sec[510 + int'($urandom % 2)] = 8'h00;
      run_good("R3", 20);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule